// File: doc/BRIEF.md
# FSK Baseband Bit Sampler with Edge Resynchronisation

This block sits behind an FSK demodulator whose output has already been sliced to a clean logic level. It recovers 1200 bit/s asynchronous characters from that line. A countdown timer derived from the system clock produces one sample strike per bit period. The block sends the input through a two-flop synchronizer. Each falling edge it sees reloads the timer with half a bit period, so the next strike lands near the centre of the new symbol. Because the phase is corrected on every falling edge, and not only at the start of a character, a local bit period that is a little off the nominal rate does not build up error across a frame.

Each character is a start bit, eight data bits sent least significant first, and a stop bit. The start level is a parameter, and the stop level is its inverse. When the stop bit is correct, the block gives a one-cycle strobe with the byte. When it is wrong, the byte is dropped and a one-cycle framing-error pulse is raised. Analog demodulation and message parsing are left to other blocks.

Top module: `fsk_bit_sampler`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `rx_byte` is 0, `rx_valid` is 0 and `frame_err` is 0.
- R2: `rx_line` passes through two flops before any use, so a change on the line reaches the edge detector and the sampler two clocks later.
- R3: A detected falling edge reloads the timer so that the next sample is taken HALF_CNT = floor(BIT_CNT/2) clocks later. Later samples follow every BIT_CNT clocks, where BIT_CNT = round(CLK_HZ/BIT_HZ).
- R4: With no falling edge on the line, sample strikes repeat every BIT_CNT clocks and run freely from reset.
- R5: While idle, a sample whose level differs from the start level leaves the block idle and produces neither `rx_valid` nor `frame_err`.
- R6: A frame is one start sample, then DATA_BITS data samples, then one stop sample. The first data sample becomes bit 0 of `rx_byte` (least significant bit first).
- R7: A stop sample at the stop level (the inverse of START_LVL) raises `rx_valid` for exactly one clock, on the clock after that sample, with the new byte on `rx_byte`. `rx_byte` then holds its value until the next `rx_valid`.
- R8: A stop sample at the start level raises `frame_err` for exactly one clock. In that case `rx_valid` stays low and `rx_byte` keeps its previous value.
- R9: START_LVL=1 gives start level 1, stop level 0 and idle level 0. START_LVL=0 gives start level 0, stop level 1 and idle level 1.
- R10: A character whose bit period is 14 or 18 clocks against a nominal 16 is still decoded correctly, as long as a falling edge occurs at least every second bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Sliced FSK baseband bit line |
| rx_byte | output | DATA_BITS | Last correctly framed data byte |
| rx_valid | output | 1 | One-cycle strobe when a new byte is on `rx_byte` |
| frame_err | output | 1 | One-cycle pulse when a stop bit has the wrong level |

## Verification
The bench sets CLK_HZ to 19200 with BIT_HZ at 1200. This gives a 16-clock bit and an 8-clock half bit, so full frames, idle gaps and bad stop bits all fit in a few thousand cycles. It builds two copies side by side, one with START_LVL=1 and one with START_LVL=0, so both polarities and their idle levels are tested on the same run. The short bit period also makes it cheap to send frames at 14 and 18 clocks per bit, where correct decoding depends on the falling-edge phase correction.

// File: rtl/fsk_samp_pkg.sv
package fsk_samp_pkg;

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_DATA = 2'd1,
        FR_STOP = 2'd2
    } frame_state_e;

    typedef struct packed {
        logic level;
        logic fall;
    } line_evt_t;

    function automatic int unsigned ratio_round(input longint unsigned num,
                                                input longint unsigned den);
        longint unsigned q;
        q = (num + den / 2) / den;
        return q[31:0];
    endfunction

    function automatic int unsigned bits_for(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/fsk_line_sync.sv
module fsk_line_sync
    import fsk_samp_pkg::*;
#(
    parameter bit IDLE_LVL = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      rx_in,
    output line_evt_t evt
);

    logic meta_q;
    logic sync_q;
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= IDLE_LVL;
            sync_q <= IDLE_LVL;
            prev_q <= IDLE_LVL;
        end else begin
            meta_q <= rx_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign evt.level = sync_q;
    assign evt.fall  = prev_q & ~sync_q;

    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (rst)
            age_q <= 2'd0;
        else if (age_q != 2'd3)
            age_q <= age_q + 2'd1;
    end

    // R2: a falling edge reported now was a 1 -> 0 step on the pin two and three clocks back
    p_fall_tracks_pin_r2: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd3 && evt.fall) |-> (!$past(rx_in, 2) && $past(rx_in, 3)));

endmodule

// File: rtl/fsk_phase_timer.sv
module fsk_phase_timer
    import fsk_samp_pkg::*;
#(
    parameter int unsigned BIT_CNT  = 16,
    parameter int unsigned HALF_CNT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic fall,
    output logic tick
);

    localparam int unsigned CW = bits_for(BIT_CNT);
    localparam logic [CW-1:0] FULL_LD = CW'(BIT_CNT - 1);
    localparam logic [CW-1:0] HALF_LD = CW'(HALF_CNT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= FULL_LD;
        else if (fall)
            cnt_q <= HALF_LD;
        else if (cnt_q == '0)
            cnt_q <= FULL_LD;
        else
            cnt_q <= cnt_q - 1'b1;
    end

    assign tick = (cnt_q == '0) && !fall;

    // R4: strikes are never back to back
    p_tick_gap_r4: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    // R3: a phase reset pushes the next strike at least one clock away
    p_fall_defers_r3: assert property (@(posedge clk) disable iff (rst)
        ((HALF_CNT > 1) && fall) |=> !tick);

endmodule

// File: rtl/fsk_frame_asm.sv
module fsk_frame_asm
    import fsk_samp_pkg::*;
#(
    parameter int unsigned DATA_BITS = 8,
    parameter bit          START_LVL = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 level,
    output logic [DATA_BITS-1:0] data,
    output logic                 valid,
    output logic                 err
);

    localparam int unsigned IW = bits_for(DATA_BITS);
    localparam logic [IW-1:0] LAST_IDX = IW'(DATA_BITS - 1);
    localparam bit STOP_LVL = !START_LVL;

    frame_state_e         st_q;
    logic [IW-1:0]        idx_q;
    logic [DATA_BITS-1:0] shreg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= FR_IDLE;
            idx_q   <= '0;
            shreg_q <= '0;
            data    <= '0;
            valid   <= 1'b0;
            err     <= 1'b0;
        end else begin
            valid <= 1'b0;
            err   <= 1'b0;
            if (tick) begin
                unique case (st_q)
                    FR_IDLE: begin
                        if (level == START_LVL) begin
                            st_q  <= FR_DATA;
                            idx_q <= '0;
                        end
                    end
                    FR_DATA: begin
                        shreg_q <= {level, shreg_q[DATA_BITS-1:1]};
                        if (idx_q == LAST_IDX)
                            st_q <= FR_STOP;
                        else
                            idx_q <= idx_q + 1'b1;
                    end
                    FR_STOP: begin
                        if (level == STOP_LVL) begin
                            data  <= shreg_q;
                            valid <= 1'b1;
                        end else begin
                            err <= 1'b1;
                        end
                        st_q <= FR_IDLE;
                    end
                    default: st_q <= FR_IDLE;
                endcase
            end
        end
    end

    // R7: the byte strobe lasts one clock
    p_valid_one_shot_r7: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    // R8: the framing pulse lasts one clock and never coincides with a byte
    p_err_one_shot_r8: assert property (@(posedge clk) disable iff (rst)
        err |=> !err);
    p_err_excludes_valid_r8: assert property (@(posedge clk) disable iff (rst)
        !(valid && err));

    // R8: the byte output moves only together with the strobe
    p_byte_moves_with_valid_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(data) |-> valid);

    // R5: a non-start level in idle keeps the assembler idle
    p_idle_holds_r5: assert property (@(posedge clk) disable iff (rst)
        (st_q == FR_IDLE && tick && level != START_LVL) |=> st_q == FR_IDLE);

endmodule

// File: rtl/fsk_bit_sampler.sv
module fsk_bit_sampler
    import fsk_samp_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 12_000_000,
    parameter int unsigned BIT_HZ    = 1200,
    parameter int unsigned DATA_BITS = 8,
    parameter bit          START_LVL = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rx_line,
    output logic [DATA_BITS-1:0] rx_byte,
    output logic                 rx_valid,
    output logic                 frame_err
);

    localparam int unsigned BIT_CNT  = ratio_round(CLK_HZ, BIT_HZ);
    localparam int unsigned HALF_CNT = BIT_CNT / 2;
    localparam bit          IDLE_LVL = !START_LVL;

    line_evt_t evt;
    logic      tick;

    fsk_line_sync #(
        .IDLE_LVL (IDLE_LVL)
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .rx_in (rx_line),
        .evt   (evt)
    );

    fsk_phase_timer #(
        .BIT_CNT  (BIT_CNT),
        .HALF_CNT (HALF_CNT)
    ) u_timer (
        .clk  (clk),
        .rst  (rst),
        .fall (evt.fall),
        .tick (tick)
    );

    fsk_frame_asm #(
        .DATA_BITS (DATA_BITS),
        .START_LVL (START_LVL)
    ) u_frame (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .level (evt.level),
        .data  (rx_byte),
        .valid (rx_valid),
        .err   (frame_err)
    );

endmodule

// File: tb/test_fsk_bit_sampler.sv
`timescale 1ns/1ps

module fsk_ref_model #(
    parameter int BITC   = 16,
    parameter int HALFC  = 8,
    parameter bit STARTV = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       line,
    output logic       m_valid,
    output logic       m_err,
    output logic [7:0] m_byte
);
    int hist[3];
    int countdown;
    int phase;
    int got;
    int acc;
    bit fall_seen;
    bit strike;
    int lvl;

    initial begin
        m_valid = 0;
        m_err   = 0;
        m_byte  = 0;
    end

    always @(posedge clk) begin
        if (rst) begin
            foreach (hist[i]) hist[i] = !STARTV;
            countdown = BITC - 1;
            phase = 0;
            got = 0;
            acc = 0;
            m_valid <= 0;
            m_err   <= 0;
            m_byte  <= 0;
        end else begin
            fall_seen = (hist[2] == 1) && (hist[1] == 0);
            strike = (countdown == 0) && !fall_seen;
            lvl = hist[1];
            m_valid <= 0;
            m_err   <= 0;
            if (strike) begin
                if (phase == 0) begin
                    if (lvl == int'(STARTV)) begin
                        phase = 1;
                        got = 0;
                        acc = 0;
                    end
                end else if (phase == 1) begin
                    acc = acc + (lvl << got);
                    got++;
                    if (got == 8) phase = 2;
                end else begin
                    if (lvl != int'(STARTV)) begin
                        m_valid <= 1;
                        m_byte  <= acc[7:0];
                    end else begin
                        m_err <= 1;
                    end
                    phase = 0;
                end
            end
            if (fall_seen) countdown = HALFC - 1;
            else if (countdown == 0) countdown = BITC - 1;
            else countdown--;
            hist[2] = hist[1];
            hist[1] = hist[0];
            hist[0] = int'(line);
        end
    end
endmodule

module test_fsk_bit_sampler;
    logic clk = 0;
    logic rst = 1;
    logic line_a = 0;
    logic line_b = 1;
    logic [7:0] byte_a, byte_b;
    logic val_a, val_b, err_a, err_b;
    logic mv_a, mv_b, me_a, me_b;
    logic [7:0] mb_a, mb_b;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] qa[$];
    logic [7:0] qb[$];
    int ea = 0;
    int eb = 0;

    always #2.5 clk = ~clk;

    fsk_bit_sampler #(.CLK_HZ(19200), .BIT_HZ(1200), .DATA_BITS(8), .START_LVL(1'b1))
        i_fsk_bit_sampler (.clk(clk), .rst(rst), .rx_line(line_a),
                           .rx_byte(byte_a), .rx_valid(val_a), .frame_err(err_a));

    fsk_bit_sampler #(.CLK_HZ(19200), .BIT_HZ(1200), .DATA_BITS(8), .START_LVL(1'b0))
        i_fsk_bit_sampler_lo (.clk(clk), .rst(rst), .rx_line(line_b),
                              .rx_byte(byte_b), .rx_valid(val_b), .frame_err(err_b));

    fsk_ref_model #(.BITC(16), .HALFC(8), .STARTV(1'b1))
        u_model_a (.clk(clk), .rst(rst), .line(line_a), .m_valid(mv_a), .m_err(me_a), .m_byte(mb_a));
    fsk_ref_model #(.BITC(16), .HALFC(8), .STARTV(1'b0))
        u_model_b (.clk(clk), .rst(rst), .line(line_b), .m_valid(mv_b), .m_err(me_b), .m_byte(mb_b));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the behavioural model (R2 R3 R4 R7 R8 timing)
    always @(negedge clk) begin
        if (!rst) begin
            chk("R3 R7 timing valid A", int'(val_a), int'(mv_a));
            chk("R2 R4 R8 timing err A", int'(err_a), int'(me_a));
            chk("R3 R7 timing valid B", int'(val_b), int'(mv_b));
            chk("R2 R4 R8 timing err B", int'(err_b), int'(me_b));
            chk("R7 byte A", int'(byte_a), int'(mb_a));
            chk("R7 byte B", int'(byte_b), int'(mb_b));
            if (val_a) qa.push_back(byte_a);
            if (val_b) qb.push_back(byte_b);
            if (err_a) ea++;
            if (err_b) eb++;
        end
    end

    task automatic put_line(input bit sel, input logic v);
        if (sel) line_b = v;
        else     line_a = v;
    endtask

    task automatic idle_bits(input bit sel, input int nbits);
        put_line(sel, sel ? 1'b1 : 1'b0);
        repeat (nbits * 16) @(posedge clk);
        #1;
    endtask

    // sel 0: START_LVL=1 copy, sel 1: START_LVL=0 copy (R9)
    task automatic send(input bit sel, input logic [7:0] b, input bit good_stop, input int per);
        logic st;
        st = sel ? 1'b0 : 1'b1;
        put_line(sel, st);
        repeat (per) @(posedge clk);
        #1;
        for (int i = 0; i < 8; i++) begin
            put_line(sel, b[i]);
            repeat (per) @(posedge clk);
            #1;
        end
        put_line(sel, good_stop ? ~st : st);
        repeat (per) @(posedge clk);
        #1;
        idle_bits(sel, 2);
    endtask

    task automatic expect_byte(input bit sel, input string req, input logic [7:0] exp);
        logic [7:0] got;
        if (sel) begin
            chk({req, " count B"}, qb.size(), 1);
            got = (qb.size() > 0) ? qb.pop_front() : 8'hxx;
        end else begin
            chk({req, " count A"}, qa.size(), 1);
            got = (qa.size() > 0) ? qa.pop_front() : 8'hxx;
        end
        chk(req, int'(got), int'(exp));
        qa.delete();
        qb.delete();
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1;
        @(negedge clk);
        chk("R1 reset byte A", int'(byte_a), 0);
        chk("R1 reset valid A", int'(val_a), 0);
        chk("R1 reset err B", int'(err_b), 0);
        @(posedge clk);
        #1;
        rst = 0;
        @(negedge clk);
        chk("R1 after reset byte B", int'(byte_b), 0);
        chk("R1 after reset valid B", int'(val_b), 0);
        @(posedge clk);
        #1;

        // R5: long idle at stop level on both copies
        idle_bits(0, 4);
        idle_bits(1, 2);
        chk("R5 idle no bytes A", qa.size(), 0);
        chk("R5 idle no bytes B", qb.size(), 0);
        chk("R5 idle no err A", ea, 0);
        chk("R5 idle no err B", eb, 0);

        // R6 R9: start=1 polarity
        send(0, 8'hA5, 1, 16); expect_byte(0, "R6 R9 A byte A5", 8'hA5);
        send(0, 8'h3C, 1, 16); expect_byte(0, "R6 A byte 3C", 8'h3C);
        send(0, 8'hFF, 1, 16); expect_byte(0, "R4 A byte FF no edges", 8'hFF);
        send(0, 8'h00, 1, 16); expect_byte(0, "R6 A byte 00", 8'h00);

        // R6 R9: start=0 polarity
        send(1, 8'h5A, 1, 16); expect_byte(1, "R6 R9 B byte 5A", 8'h5A);
        send(1, 8'h01, 1, 16); expect_byte(1, "R6 B byte 01 lsb first", 8'h01);
        send(1, 8'h80, 1, 16); expect_byte(1, "R6 B byte 80 msb last", 8'h80);

        // R8: wrong stop level
        send(0, 8'h77, 0, 16);
        chk("R8 A no byte on bad stop", qa.size(), 0);
        chk("R8 A one framing pulse", ea, 1);
        chk("R8 A byte held", int'(byte_a), 8'h00);
        send(1, 8'hC3, 0, 16);
        chk("R8 B no byte on bad stop", qb.size(), 0);
        chk("R8 B one framing pulse", eb, 1);
        chk("R8 B byte held", int'(byte_b), 8'h80);

        // R10: off-rate bit periods corrected by edge resync
        send(1, 8'h55, 1, 18); expect_byte(1, "R10 B slow 55", 8'h55);
        send(1, 8'h55, 1, 14); expect_byte(1, "R10 B fast 55", 8'h55);
        send(0, 8'hAA, 1, 18); expect_byte(0, "R10 A slow AA", 8'hAA);
        send(0, 8'hAA, 1, 14); expect_byte(0, "R10 A fast AA", 8'hAA);
        chk("R8 no stray framing A", ea, 1);
        chk("R8 no stray framing B", eb, 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule